// File: doc/BRIEF.md
# Parallel Switch Layer Selector

This block makes the spreading decision for one external input of a parallel packet switch. That switch is built from K slower center-stage layers. In each external time slot the input may present one cell, tagged with the external output it is bound for. The block answers with the layer that the cell is to be sent on. An internal link runs slower than the external line, so a cell occupies its link for W external slots. Cells for one output must also be spread so that the output can read them back without stalling.

The block keeps two sliding-window exclusion sets. The first is a busy down-counter for each of this input's K internal links. It excludes any layer that is still transmitting. The second is a local history for each output of the layers that carried its last W-1 cells. The cell goes to the lowest-indexed layer in the intersection of the two sets. With W < (K+2)/2 that intersection can never be empty. When the window is too wide for K, the intersection can become empty. The block then raises a sticky conflict flag and sends the cell on the lowest free link, so that the cell is still placed.

Top module: `ppsLayerSel`

## Requirements
- R1: After reset, selVld and conflict are 0, every link is free and every output history is empty, so the first cell goes to layer 0.
- R2: A cell presented with arrVld high at a clock edge produces selVld high with its selLayer after that same edge. selVld is low after an edge at which arrVld was low.
- R3: A layer assigned in slot t is not assigned again in slots t+1 to t+W-1, whatever the destination. In slot t+W it is free again.
- R4: While the intersection is non-empty, a cell for output d never goes to a layer that carried one of d's previous W-1 cells.
- R5: When several layers are both free and allowed, the one with the lowest index is chosen.
- R6: A slot with arrVld low assigns nothing and leaves every output history unchanged. The link timers still count down in that slot.
- R7: If no layer is both free and allowed, conflict rises with that cell's selVld, and the cell goes to the lowest-indexed free link.
- R8: Once set, conflict stays high until reset.
- R9: With W < (K+2)/2, conflict never rises.
- R10: The histories are kept per output: layers recently used by other outputs do not restrict a cell for output d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one external time slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| arrVld | input | 1 | A cell arrives in this slot |
| arrDest | input | clog2(N) | Destination output of the arriving cell |
| selVld | output | 1 | Registered: a layer was assigned in the previous slot |
| selLayer | output | clog2(K) | Registered: index of the assigned layer |
| conflict | output | 1 | Sticky: an empty intersection has occurred |

## Verification
The hardest case to reach is the empty intersection. The only free link must also be the one that carried the destination's most recent cell. That state needs a window too wide for K, and a cell order in which other outputs fill the remaining links just as the repeated output returns. The bench uses a second instance with K=3 and W=3. It sends output 0 to layer 0 and then two cells for output 1, which take layers 1 and 2. Output 0 then comes back in the slot where only layer 0 has expired. A second case is built from the interleaved sequence in which output 3 must go to layer 1: its last layer is 0 and layer 2 is still busy.

// File: rtl/ppsLayerSelPkg.sv
package ppsLayerSelPkg;
  typedef struct packed {
    logic commit;   // a cell is assigned this slot
    logic clash;    // intersection was empty, fallback used
  } selStrobe_t;
endpackage

// File: rtl/ppsLayerSelDp.sv
module ppsLayerSelDp #(
  parameter int K = 3,
  parameter int N = 4,
  parameter int W = 2,
  localparam int LW = (K > 1) ? $clog2(K) : 1,
  localparam int DW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(W + 1),
  localparam int HD = (W > 1) ? W - 1 : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DW-1:0]                arrDest,
  input  ppsLayerSelPkg::selStrobe_t   st,
  input  logic [LW-1:0]                pickLayer,
  output logic [K-1:0]                 freeMask,
  output logic [K-1:0]                 allowMask
);
  logic [CW-1:0] busyCnt [K];
  logic [LW-1:0] histLayer [N][HD];
  logic [HD-1:0] histVld [N];

  generate
    for (genvar l = 0; l < K; l++) begin : gLink
      assign freeMask[l] = (busyCnt[l] == '0);
      always_ff @(posedge clk) begin
        if (!rstN) busyCnt[l] <= '0;
        else if (st.commit && pickLayer == LW'(l)) busyCnt[l] <= CW'(W - 1);
        else if (busyCnt[l] != '0) busyCnt[l] <= busyCnt[l] - 1'b1;
      end
    end
  endgenerate

  always_comb begin
    allowMask = '1;
    for (int h = 0; h < HD; h++)
      if (histVld[arrDest][h]) allowMask[histLayer[arrDest][h]] = 1'b0;
  end

  generate
    for (genvar d = 0; d < N; d++) begin : gHist
      always_ff @(posedge clk) begin
        if (!rstN) begin
          histVld[d] <= '0;
          for (int h = 0; h < HD; h++) histLayer[d][h] <= '0;
        end else if (st.commit && arrDest == DW'(d)) begin
          histLayer[d][0] <= pickLayer;
          histVld[d][0]   <= 1'b1;
          for (int h = 1; h < HD; h++) begin
            histLayer[d][h] <= histLayer[d][h-1];
            histVld[d][h]   <= histVld[d][h-1];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ppsLayerSelCtl.sv
module ppsLayerSelCtl #(
  parameter int K = 3,
  localparam int LW = (K > 1) ? $clog2(K) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         arrVld,
  input  logic [K-1:0]                 freeMask,
  input  logic [K-1:0]                 allowMask,
  output ppsLayerSelPkg::selStrobe_t   st,
  output logic [LW-1:0]                pickLayer,
  output logic                         selVld,
  output logic [LW-1:0]                selLayer,
  output logic                         conflict
);
  logic [K-1:0] inter;
  logic [K-1:0] candMask;

  assign inter    = freeMask & allowMask;
  assign candMask = (inter != '0) ? inter : freeMask;

  always_comb begin
    pickLayer = '0;
    for (int l = K - 1; l >= 0; l--)
      if (candMask[l]) pickLayer = LW'(l);
  end

  assign st.commit = arrVld;
  assign st.clash  = arrVld && (inter == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selVld   <= 1'b0;
      selLayer <= '0;
      conflict <= 1'b0;
    end else begin
      selVld <= arrVld;
      if (arrVld) selLayer <= pickLayer;
      if (st.clash) conflict <= 1'b1;
    end
  end
endmodule

// File: rtl/ppsLayerSel.sv
module ppsLayerSel #(
  parameter int K = 3,
  parameter int N = 4,
  parameter int W = 2,
  localparam int LW = (K > 1) ? $clog2(K) : 1,
  localparam int DW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          arrVld,
  input  logic [DW-1:0] arrDest,
  output logic          selVld,
  output logic [LW-1:0] selLayer,
  output logic          conflict
);
  ppsLayerSelPkg::selStrobe_t st;
  logic [LW-1:0] pickLayer;
  logic [K-1:0]  freeMask;
  logic [K-1:0]  allowMask;

  ppsLayerSelDp #(.K(K), .N(N), .W(W)) dp_i (
    .clk(clk), .rstN(rstN), .arrDest(arrDest), .st(st),
    .pickLayer(pickLayer), .freeMask(freeMask), .allowMask(allowMask)
  );

  ppsLayerSelCtl #(.K(K)) ctl_i (
    .clk(clk), .rstN(rstN), .arrVld(arrVld), .freeMask(freeMask),
    .allowMask(allowMask), .st(st), .pickLayer(pickLayer),
    .selVld(selVld), .selLayer(selLayer), .conflict(conflict)
  );
endmodule

// File: rtl/ppsLayerSelChk.sv
module ppsLayerSelChk #(
  parameter int K = 3,
  parameter int N = 4,
  parameter int W = 2,
  localparam int LW = (K > 1) ? $clog2(K) : 1,
  localparam int DW = (N > 1) ? $clog2(N) : 1,
  localparam int SW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          arrVld,
  input logic [DW-1:0] arrDest,
  input logic          selVld,
  input logic [LW-1:0] selLayer,
  input logic          conflict
);
  logic [SW-1:0] sinceUse [K];
  logic [LW-1:0] lastLayer [N];
  logic [N-1:0]  lastVld;
  logic [DW-1:0] destQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ   <= '0;
      lastVld <= '0;
      for (int l = 0; l < K; l++) sinceUse[l] <= SW'(W);
      for (int d = 0; d < N; d++) lastLayer[d] <= '0;
    end else begin
      if (arrVld) destQ <= arrDest;
      for (int l = 0; l < K; l++)
        if (selVld && selLayer == LW'(l)) sinceUse[l] <= SW'(1);
        else if (sinceUse[l] < SW'(W)) sinceUse[l] <= sinceUse[l] + 1'b1;
      if (selVld) begin
        lastLayer[destQ] <= selLayer;
        lastVld[destQ]   <= 1'b1;
      end
    end
  end

  AST_SEL_AFTER_ARR: assert property (@(posedge clk) disable iff (!rstN)
    arrVld |=> selVld); // R2
  AST_NO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !arrVld |=> !selVld); // R6
  AST_LAYER_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    selVld |-> (int'(selLayer) < K)); // R2
  AST_LINK_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    selVld |-> (sinceUse[selLayer] >= SW'(W))); // R3
  AST_NO_REPEAT_LAYER: assert property (@(posedge clk) disable iff (!rstN)
    (selVld && !conflict && lastVld[destQ]) |-> (selLayer != lastLayer[destQ])); // R4
  AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    conflict |=> conflict); // R8
  AST_CONFLICT_WITH_CELL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(conflict) |-> selVld); // R7
endmodule

bind ppsLayerSel ppsLayerSelChk #(.K(K), .N(N), .W(W)) chk_i (
  .clk(clk), .rstN(rstN), .arrVld(arrVld), .arrDest(arrDest),
  .selVld(selVld), .selLayer(selLayer), .conflict(conflict)
);

// File: tb/ppsLayerSel_tb_top.sv
module ppsLayerSel_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arrVldA = 1'b0, arrVldB = 1'b0;
  logic [1:0] arrDestA = '0;
  logic [0:0] arrDestB = '0;
  logic selVldA, selVldB, conflictA, conflictB;
  logic [1:0] selLayerA, selLayerB;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // K=3, W=2: intersection can never be empty
  ppsLayerSel #(.K(3), .N(4), .W(2)) dut_i (
    .clk(clk), .rstN(rstN), .arrVld(arrVldA), .arrDest(arrDestA),
    .selVld(selVldA), .selLayer(selLayerA), .conflict(conflictA));

  // K=3, W=3: no speedup, conflicts reachable
  ppsLayerSel #(.K(3), .N(2), .W(3)) dutLow_i (
    .clk(clk), .rstN(rstN), .arrVld(arrVldB), .arrDest(arrDestB),
    .selVld(selVldB), .selLayer(selLayerB), .conflict(conflictB));

  task automatic chk(input int act, input int exp, input string tag);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cellA(input int dest, input int expLayer, input string tag);
    arrVldA = 1'b1; arrDestA = 2'(dest);
    @(negedge clk);
    arrVldA = 1'b0;
    chk(int'(selVldA), 1, {tag, " selVld"});
    chk(int'(selLayerA), expLayer, {tag, " layer"});
    chk(int'(conflictA), 0, "R9 conflict low");
  endtask

  task automatic idleA(input string tag);
    arrVldA = 1'b0;
    @(negedge clk);
    chk(int'(selVldA), 0, tag);
  endtask

  task automatic cellB(input int dest, input int expLayer, input int expConf, input string tag);
    arrVldB = 1'b1; arrDestB = 1'(dest);
    @(negedge clk);
    arrVldB = 1'b0;
    chk(int'(selLayerB), expLayer, {tag, " layer"});
    chk(int'(conflictB), expConf, {tag, " conflict"});
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk(int'(selVldA), 0, "R1 selVld after reset");
    chk(int'(conflictA), 0, "R1 conflict after reset");
    chk(int'(conflictB), 0, "R8 conflict cleared by reset");
  endtask

  task automatic testSpread();
    cellA(0, 0, "R1 first cell to layer 0");
    cellA(1, 1, "R3 layer 0 busy, R5 lowest");
    cellA(2, 0, "R3 layer 0 free after W slots");
    idleA("R6 idle slot no selVld");
    cellA(3, 0, "R10 other outputs' layer 0 not excluded");
    cellA(1, 2, "R4 output 1 avoids layer 1");
    cellA(3, 1, "R4 R5 worked case picks layer 1");
    cellA(2, 2, "R6 output 2 history kept over idle");
    idleA("R2 selVld drops after idle");
  endtask

  task automatic testConflict();
    cellB(0, 0, 0, "R7 setup out0");
    cellB(1, 1, 0, "R7 setup out1");
    cellB(1, 2, 0, "R7 setup out1 again");
    cellB(0, 0, 1, "R7 empty intersection falls back");
    arrVldB = 1'b0;
    repeat (2) @(negedge clk);
    chk(int'(conflictB), 1, "R8 conflict held over idle");
    cellB(1, 0, 1, "R8 conflict held after clean cell");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testSpread();
    testConflict();
    testReset();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule